// File: doc/BRIEF.md
# MFM Write-Channel Encoder with Address-Mark Insertion

This block turns bytes into a stream of modified-frequency-modulation channel half-cells for a magnetic write path. Every data bit becomes two half-cells: a clock position followed by a data position. Each half-cell is a single flag that says whether a flux transition is written there. One half-cell leaves the block on each clock cycle in which the cell-rate enable is high. At the nominal 100 ns half-cell, one data bit takes 200 ns. Bytes are shifted out most significant bit first. The block always runs, so the channel never stalls: when no byte is waiting, it writes zero bytes as gap fill.

The block takes bytes through a valid/ready handshake into a one-byte holding stage. A one-cycle sync request arms a framing sequence. That sequence is a run of zero bytes, so the reader's phase-locked loop can lock, followed by one or more address-mark bytes. Each address mark is the value A1 written with one clock transition left out on purpose, so that no ordinary data can copy it. The sequence starts at the next byte boundary and goes ahead of any byte that is already held. The last data bit is kept across byte boundaries, through the fill bytes and through the preamble and marks, so the clock rule never breaks at a seam.

Top module: `mfm_sync_encoder`

## Requirements
- R1: A data bit of 1 is written as no transition in its clock half-cell and a transition in its data half-cell (channel pair 01).
- R2: A data bit of 0 whose preceding data bit was 1 is written with no transition in either half-cell (pair 00).
- R3: A data bit of 0 whose preceding data bit was 0 is written as a clock-half transition only (pair 10). The preceding bit is carried across every byte boundary, and its value after reset is 0.
- R4: Accepted bytes go out most significant bit first, in the order they were accepted. While the source keeps a byte on offer, consecutive bytes follow with no fill between them.
- R5: A sync request seen while the block is not busy raises sync_busy on the next cycle. At the next byte boundary the block then writes PRE_BYTES zero bytes and then MARKS address marks, all ahead of any held data byte.
- R6: Every address mark is the byte A1 with the clock transition of bit index 2 (LSB = 0, the sixth bit sent) left out, which gives the 16-half-cell word 0x4489 with the first half-cell as the MSB.
- R7: in_ready is high exactly when the holding stage is empty. A byte is accepted on a cycle with in_valid and in_ready both high, and in_ready is low on the next cycle.
- R8: The outputs change only on cycles where cell_en is high. cell_dphase is 0 for a clock half-cell and 1 for a data half-cell, and it alternates starting with a clock half-cell.
- R9: During synchronous active-low reset, cell_out is 0, cell_dphase is 1, in_ready is 1 and sync_busy is 0.
- R10: In the output stream, any two transitions are separated by at least one and at most three empty half-cells.
- R11: A sync request that arrives while sync_busy is high is ignored. The sequence is not lengthened or repeated, exactly MARKS marks are written, and sync_busy falls once the last mark is loaded.
- R12: When no byte is held and no sync sequence is pending, the block writes zero bytes. Words are aligned to 16 half-cells counted from reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cell_en | input | 1 | Half-cell rate enable; one half-cell per high cycle |
| sync_req | input | 1 | Arms the preamble and address-mark sequence |
| in_data | input | 8 | Byte offered for writing |
| in_valid | input | 1 | in_data is valid |
| in_ready | output | 1 | Holding stage is empty and will accept a byte |
| sync_busy | output | 1 | Sync sequence pending or in progress |
| cell_out | output | 1 | Transition flag of the current half-cell |
| cell_dphase | output | 1 | 1 when cell_out is a data half-cell, 0 for a clock half-cell |

## Verification
All 256 byte values are written, in two passes. The first pass sends them in ascending order with cell_en high on every cycle. The second pass sends them in a scrambled order with cell_en high on one cycle in three. Between them, the two passes cover every pairing of a last bit with a following first bit at byte seams, so any error in carrying the previous bit across bytes shows up against the 01/00/10 pair rule. A single all-ones byte written before the framing sequence ends in a 1, so the first preamble bit must come out as 00 rather than 10. A second sync request made while busy must not change the number of preamble zero bytes or the number of exact 0x4489 marks found in the decoded stream.

// File: rtl/mfm_enc_pkg.sv
// Shared constants and the byte-source type for the MFM encoder.
package mfm_enc_pkg;
    localparam int          BYTE_W    = 8;
    localparam logic [7:0]  MARK_BYTE = 8'hA1;
    // LSB-based index of the mark bit whose clock transition is left out
    localparam int          MISS_IDX  = 2;

    typedef enum logic [1:0] {
        SRC_FILL,
        SRC_PRE,
        SRC_MARK,
        SRC_DATA
    } src_e;
endpackage

// File: rtl/mfm_byte_sched.sv
// Chooses the byte the serializer loads at each byte boundary.
// Order of precedence: an armed or running sync sequence (preamble
// zeros, then marks), then the held data byte, then zero fill.
// Assumes take pulses for one cycle at the boundary where next_* is loaded.
module mfm_byte_sched
    import mfm_enc_pkg::*;
#(
    parameter int PRE_BYTES = 12,
    parameter int MARKS     = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic              sync_req,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic              sync_busy,
    output logic [BYTE_W-1:0] next_byte,
    output src_e              next_src
);
    localparam int SEQ_LEN = PRE_BYTES + MARKS;
    localparam int CNT_W   = $clog2(SEQ_LEN + 1);

    logic              sync_pend;
    logic              seq_act;
    logic              seq_go;
    logic [CNT_W-1:0]  seq_cnt;
    logic [CNT_W-1:0]  seq_idx;
    logic [CNT_W-1:0]  seq_nxt;
    logic              hold_full;
    logic [BYTE_W-1:0] hold_q;

    assign seq_go    = seq_act | sync_pend;
    assign seq_idx   = seq_act ? seq_cnt : '0;
    assign seq_nxt   = seq_idx + 1'b1;
    assign in_ready  = !hold_full;
    assign sync_busy = seq_go;

    // Select the source and value of the next byte
    always_comb begin
        if (seq_go) begin
            if (seq_idx < CNT_W'(PRE_BYTES)) begin
                next_src  = SRC_PRE;
                next_byte = '0;
            end else begin
                next_src  = SRC_MARK;
                next_byte = MARK_BYTE;
            end
        end else if (hold_full) begin
            next_src  = SRC_DATA;
            next_byte = hold_q;
        end else begin
            next_src  = SRC_FILL;
            next_byte = '0;
        end
    end

    // Arm on request and step through the preamble and mark sequence
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_pend <= 1'b0;
            seq_act   <= 1'b0;
            seq_cnt   <= '0;
        end else begin
            if (sync_req && !seq_go) begin
                sync_pend <= 1'b1;
            end
            if (take && seq_go) begin
                sync_pend <= 1'b0;
                if (seq_nxt == CNT_W'(SEQ_LEN)) begin
                    seq_act <= 1'b0;
                    seq_cnt <= '0;
                end else begin
                    seq_act <= 1'b1;
                    seq_cnt <= seq_nxt;
                end
            end
        end
    end

    // One-byte holding stage behind the valid/ready handshake
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_full <= 1'b0;
            hold_q    <= '0;
        end else if (in_valid && !hold_full) begin
            hold_full <= 1'b1;
            hold_q    <= in_data;
        end else if (take && next_src == SRC_DATA) begin
            hold_full <= 1'b0;
        end
    end

    a_r7_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    a_r5_request_arms: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_req && !sync_busy) |=> sync_busy);

    a_r5_held_data_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (take && sync_busy) |=> !in_ready || $past(in_ready));
endmodule

// File: rtl/mfm_serializer.sv
// Shifts the current byte out MSB first, two half-cells per bit.
// take marks the last half-cell of a byte, where the next byte is loaded.
// Assumes the scheduler presents a valid next byte on every cycle.
module mfm_serializer
    import mfm_enc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cell_en,
    input  logic [BYTE_W-1:0] next_byte,
    input  src_e              next_src,
    output logic              take,
    output logic              cur_bit,
    output logic              half,
    output logic              clk_suppress
);
    localparam int CNT_W    = $clog2(BYTE_W);
    localparam int LAST_BIT = BYTE_W - 1;
    localparam int MISS_POS = BYTE_W - 1 - MISS_IDX;

    logic [BYTE_W-1:0] sh_q;
    logic [CNT_W-1:0]  bit_cnt;
    logic              is_mark;

    assign cur_bit      = sh_q[BYTE_W-1];
    assign take         = cell_en && half && (bit_cnt == CNT_W'(LAST_BIT));
    assign clk_suppress = is_mark && (bit_cnt == CNT_W'(MISS_POS));

    // Advance through clock half, data half, and the bit and byte positions
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q    <= '0;
            bit_cnt <= '0;
            half    <= 1'b0;
            is_mark <= 1'b0;
        end else if (cell_en) begin
            if (!half) begin
                half <= 1'b1;
            end else begin
                half <= 1'b0;
                if (bit_cnt == CNT_W'(LAST_BIT)) begin
                    sh_q    <= next_byte;
                    bit_cnt <= '0;
                    is_mark <= (next_src == SRC_MARK);
                end else begin
                    sh_q    <= {sh_q[BYTE_W-2:0], 1'b0};
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/mfm_cell_coder.sv
// Applies the MFM clock rule and registers the channel half-cell.
// Keeps the last data bit across all byte boundaries; its reset value is 0.
// Assumes half alternates on each cell_en and cur_bit holds across a bit.
module mfm_cell_coder (
    input  logic clk,
    input  logic rst_n,
    input  logic cell_en,
    input  logic half,
    input  logic cur_bit,
    input  logic clk_suppress,
    output logic cell_out,
    output logic cell_dphase
);
    logic prev_bit;
    logic [2:0] zero_run;
    logic cell_d;

    // Value of the half-cell about to be written
    always_comb begin
        if (half) cell_d = cur_bit;
        else      cell_d = !cur_bit && !prev_bit && !clk_suppress;
    end

    // Register the half-cell and remember the last data bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cell_out    <= 1'b0;
            cell_dphase <= 1'b1;
            prev_bit    <= 1'b0;
        end else if (cell_en) begin
            cell_out    <= cell_d;
            cell_dphase <= half;
            if (half) prev_bit <= cur_bit;
        end
    end

    // Count empty half-cells written since the last transition
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            zero_run <= 3'd0;
        end else if (cell_en) begin
            if (cell_d)                 zero_run <= 3'd0;
            else if (zero_run != 3'd7)  zero_run <= zero_run + 3'd1;
        end
    end

    a_r10_no_adjacent: assert property (@(posedge clk) disable iff (!rst_n)
        (cell_en && cell_out) |=> !cell_out);

    a_r10_max_gap: assert property (@(posedge clk) disable iff (!rst_n)
        zero_run <= 3'd3);

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cell_en |=> ($stable(cell_out) && $stable(cell_dphase)));

    a_r8_to_data: assert property (@(posedge clk) disable iff (!rst_n)
        (cell_en && !cell_dphase) |=> cell_dphase);

    a_r8_to_clock: assert property (@(posedge clk) disable iff (!rst_n)
        (cell_en && cell_dphase) |=> !cell_dphase);

    a_r6_gap_in_zero_run: assert property (@(posedge clk) disable iff (!rst_n)
        (cell_en && !half && clk_suppress) |-> (!cur_bit && !prev_bit));
endmodule

// File: rtl/mfm_sync_encoder.sv
// Top of the MFM write-channel encoder. Bytes come in through a one-byte
// holding stage, are serialized MSB first and coded into half-cells.
// A sync request inserts PRE_BYTES zero bytes and MARKS address marks.
// Assumes PRE_BYTES + MARKS >= 1 and that cell_en is a single-cycle tick.
module mfm_sync_encoder
    import mfm_enc_pkg::*;
#(
    parameter int PRE_BYTES = 12,
    parameter int MARKS     = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cell_en,
    input  logic       sync_req,
    input  logic [7:0] in_data,
    input  logic       in_valid,
    output logic       in_ready,
    output logic       sync_busy,
    output logic       cell_out,
    output logic       cell_dphase
);
    logic              take;
    logic              cur_bit;
    logic              half;
    logic              clk_suppress;
    logic [BYTE_W-1:0] next_byte;
    src_e              next_src;

    mfm_byte_sched #(
        .PRE_BYTES (PRE_BYTES),
        .MARKS     (MARKS)
    ) u_sched (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (take),
        .sync_req  (sync_req),
        .in_data   (in_data),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .sync_busy (sync_busy),
        .next_byte (next_byte),
        .next_src  (next_src)
    );

    mfm_serializer u_ser (
        .clk          (clk),
        .rst_n        (rst_n),
        .cell_en      (cell_en),
        .next_byte    (next_byte),
        .next_src     (next_src),
        .take         (take),
        .cur_bit      (cur_bit),
        .half         (half),
        .clk_suppress (clk_suppress)
    );

    mfm_cell_coder u_coder (
        .clk          (clk),
        .rst_n        (rst_n),
        .cell_en      (cell_en),
        .half         (half),
        .cur_bit      (cur_bit),
        .clk_suppress (clk_suppress),
        .cell_out     (cell_out),
        .cell_dphase  (cell_dphase)
    );

    a_r11_busy_while_sequencing: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_busy && !take) |=> sync_busy);
endmodule

// File: tb/sim_mfm_sync_encoder.sv
`timescale 1ns/1ps
module sim_mfm_sync_encoder;
    localparam int PRE  = 3;
    localparam int MK   = 2;
    localparam int MAXC = 8192;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cell_en = 1'b0;
    logic sync_req = 1'b0;
    logic in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic in_ready, sync_busy, cell_out, cell_dphase;

    int checks = 0;
    int errors = 0;
    bit cap_on = 1'b0;
    bit done = 1'b0;
    int mode = 0;
    int tick = 0;
    int ncell = 0;
    logic cells [MAXC];
    logic last_out = 1'b0;
    logic last_ph = 1'b1;
    logic [7:0] sent [256];

    always #2 clk = ~clk;

    mfm_sync_encoder #(.PRE_BYTES(PRE), .MARKS(MK)) u0 (
        .clk(clk), .rst_n(rst_n), .cell_en(cell_en), .sync_req(sync_req),
        .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .sync_busy(sync_busy), .cell_out(cell_out), .cell_dphase(cell_dphase)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Capture emitted half-cells and drive the cell-rate enable
    always @(negedge clk) begin
        if (cap_on) begin
            if (cell_en) begin
                if (ncell < MAXC) begin
                    cells[ncell] = cell_out;
                    chk(cell_dphase == ncell[0], "R8", "half-cell phase", cell_dphase, ncell[0]);
                    ncell++;
                end
            end else begin
                chk(cell_out == last_out && cell_dphase == last_ph, "R8", "hold without enable",
                    {cell_out, cell_dphase}, {last_out, last_ph});
            end
            last_out = cell_out;
            last_ph  = cell_dphase;
        end
        tick++;
        cell_en = (mode == 0) ? 1'b1 : (tick % 3 == 0);
    end

    task automatic ticks(input int n);
        repeat ((mode == 0) ? n : 3 * n) @(negedge clk);
    endtask

    task automatic push(input logic [7:0] b);
        bit acc;
        in_data  = b;
        in_valid = 1'b1;
        do begin
            acc = in_ready;
            @(negedge clk);
        end while (!acc);
        chk(!in_ready, "R7", "ready after accept", in_ready, 0);
        in_valid = 1'b0;
    endtask

    function automatic logic [7:0] dbyte(input int w);
        logic [7:0] v;
        for (int j = 0; j < 8; j++) v[7-j] = cells[16*w + 2*j + 1];
        return v;
    endfunction

    function automatic logic [15:0] word16(input int w);
        logic [15:0] v;
        for (int j = 0; j < 16; j++) v[15-j] = cells[16*w + j];
        return v;
    endfunction

    task automatic analyze();
        int nw, run, badg, f, mk0, base, e1, e2, e3, z, nm, tz;
        logic prev, c, d;
        nw = ncell / 16;
        run = 1; badg = 0;
        for (int i = 0; i < ncell; i++) begin
            if (cells[i]) begin
                if (run < 1) badg++;
                run = 0;
            end else begin
                run++;
                if (run > 3) badg++;
            end
        end
        chk(badg == 0, "R10", "transition spacing violations", badg, 0);

        f = -1;
        for (int w = 0; w < nw; w++) if (f < 0 && dbyte(w) != 8'h00) f = w;
        chk(f > 0 && dbyte(f) == 8'hFF, "R4", "first written byte", f, 8'hFF);
        if (f <= 0) return;
        mk0  = f + PRE + 1;
        base = mk0 + MK;

        prev = 1'b0; e1 = 0; e2 = 0; e3 = 0;
        for (int w = 0; w < nw; w++) begin
            if (w >= mk0 && w < base) begin
                prev = 1'b1;
                continue;
            end
            for (int j = 0; j < 8; j++) begin
                c = cells[16*w + 2*j];
                d = cells[16*w + 2*j + 1];
                if (d) begin
                    if (c) e1++;
                end else if (prev) begin
                    if (c) e2++;
                end else begin
                    if (!c) e3++;
                end
                prev = d;
            end
        end
        chk(e1 == 0, "R1", "one-bit pairs not 01", e1, 0);
        chk(e2 == 0, "R2", "zero-after-one pairs not 00", e2, 0);
        chk(e3 == 0, "R3", "zero-after-zero pairs not 10", e3, 0);

        z = 0;
        for (int w = 0; w < f; w++) if (dbyte(w) != 8'h00) z++;
        chk(z == 0, "R12", "idle fill before data", z, 0);

        z = 0;
        for (int k = 1; k <= PRE; k++) if (word16(f + k) == 16'h4489 || dbyte(f + k) != 8'h00) z++;
        chk(z == 0, "R5", "preamble zero bytes", z, 0);

        for (int k = 0; k < MK; k++)
            chk(word16(mk0 + k) == 16'h4489, "R6", "address mark word", word16(mk0 + k), 16'h4489);

        nm = 0;
        for (int w = 0; w < nw; w++) if (word16(w) == 16'h4489) nm++;
        chk(nm == MK, "R11", "number of marks", nm, MK);

        for (int i = 0; i < 256; i++)
            chk(base + i < nw && dbyte(base + i) == sent[i], "R4", "data byte order",
                (base + i < nw) ? dbyte(base + i) : -1, sent[i]);

        tz = 0;
        for (int w = base + 256; w < nw; w++) if (dbyte(w) != 8'h00) tz++;
        chk(tz == 0 && nw > base + 256, "R12", "fill after data", tz, 0);
    endtask

    task automatic run_phase(input int m);
        logic [7:0] b;
        mode = m;
        cap_on = 1'b0;
        rst_n = 1'b0;
        in_valid = 1'b0;
        sync_req = 1'b0;
        repeat (4) @(negedge clk);
        chk(cell_out == 1'b0, "R9", "reset cell_out", cell_out, 0);
        chk(cell_dphase == 1'b1, "R9", "reset cell_dphase", cell_dphase, 1);
        chk(in_ready == 1'b1, "R9", "reset in_ready", in_ready, 1);
        chk(sync_busy == 1'b0, "R9", "reset sync_busy", sync_busy, 0);
        #1;
        ncell = 0;
        last_out = 1'b0;
        last_ph = 1'b1;
        rst_n = 1'b1;
        cap_on = 1'b1;
        @(negedge clk);
        ticks(40);
        push(8'hFF);
        while (!in_ready) @(negedge clk);
        sync_req = 1'b1;
        @(negedge clk);
        sync_req = 1'b0;
        chk(sync_busy == 1'b1, "R5", "busy after request", sync_busy, 1);
        repeat (2) @(negedge clk);
        sync_req = 1'b1;   // R11: repeat while busy must be ignored
        @(negedge clk);
        sync_req = 1'b0;
        for (int i = 0; i < 256; i++) begin
            b = (m == 0) ? 8'(i) : 8'((i * 167 + 89) & 255);
            sent[i] = b;
            push(b);
        end
        ticks(30 * 16);
        chk(sync_busy == 1'b0, "R11", "busy cleared after sequence", sync_busy, 0);
        cap_on = 1'b0;
        analyze();
    endtask

    initial begin
        @(negedge clk);
        run_phase(0);
        run_phase(1);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule